// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block serialises one byte at a time onto an asynchronous serial line. Software programs the frame shape through a 32-bit line-control register: a data length from five to eight bits, an optional parity bit that can be even, odd or forced to a fixed level, and a stop period of one, one and a half or two bit times. A byte written to the holding register goes out as a start bit, then the data bits least significant first, then the parity bit when parity is enabled, then the stop period. Each bit lasts sixteen pulses of the externally generated baud tick.

The line-control register also carries a break control, which pulls the serial output low while the frame engine keeps running underneath, and a divisor-latch select. That select steers writes and reads at the data offset and the interrupt-enable offset to the two bytes of the baud divisor. The divisor bytes are exported for a baud generator outside the block. A busy flag and a transmitter-empty flag report progress. The word length, stop and parity settings are captured when each frame starts, so a register write during a frame does not change that frame.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the serial output is 1, busy is 0, transmitter-empty is 1, and the line-control register reads 0.
- R2: The line-control register sits at byte offset 0xC. Bits 1:0 select 5, 6, 7 or 8 data bits (codes 0 to 3). Bit 2 is the stop select, bit 3 parity enable, bit 4 even select, bit 5 sticky parity, bit 6 break and bit 7 divisor-latch select. Bits 31:8 read as 0.
- R3: A frame is one start bit at 0, then the data bits least significant first, then stop at 1. The output idles at 1 and each bit lasts 16 baud ticks.
- R4: With parity enabled the parity bit follows the data bits. With even select at 1 the ones in data plus parity are even, and with even select at 0 they are odd.
- R5: With parity enabled and sticky parity at 1, the parity bit is the inverse of the even select bit.
- R6: With parity enable at 0 no parity bit is sent, and the even select and sticky settings have no effect.
- R7: The stop period is 16 ticks when bit 2 is 0. When bit 2 is 1 it is 24 ticks with a 5-bit word and 32 ticks with 6 to 8 bit words.
- R8: While break is 1 the serial output is 0. The frame still runs to its normal end, and the frame length is unchanged.
- R9: With divisor-latch select at 1, writes and reads at offset 0x0 go to the divisor low byte and at offset 0x4 go to the high byte; divisor_o is {high, low}. With it at 0, offset 0x0 writes the holding register and offset 0x4 is the interrupt-enable byte. A write at 0x0 while the select is 1 starts no frame.
- R10: Transmitter-empty is 1 only when the holding register is empty and no frame is running. A holding write while a frame runs is kept if the holding slot is free; a holding write while the slot is full is dropped.
- R11: The word length, stop and parity settings are captured at frame start. A change written during a frame does not alter that frame.
- R12: Bit timing advances only on cycles where baud_tick_i is 1. Without ticks the line holds its level and busy stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | Pulse at 16 times the bit rate |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| divisor_o | output | 16 | Baud divisor {high byte, low byte} |
| txd_o | output | 1 | Serial output |
| busy_o | output | 1 | A frame is being shifted |
| temt_o | output | 1 | Holding register empty and no frame running |

## Verification
Some rules are checked by the assertions on every cycle. Break holds the line low and an idle line without break sits at 1. Transmitter-empty never coincides with busy. The captured frame settings stay stable for a whole frame. The frame engine freezes on cycles without a tick. A write at the control offset appears in the register on the next cycle. The bench scenarios cover what needs a whole frame to judge: the bit order, the parity values under each mode, the three stop lengths, the frame length being kept under break and under a mid-frame reconfiguration, the divisor-latch steering, and a third byte being dropped while the holding slot is full.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int REG_AW = 4;
  localparam int REG_DW = 32;
  localparam logic [REG_AW-1:0] OFS_DATA = 4'h0;
  localparam logic [REG_AW-1:0] OFS_IER  = 4'h4;
  localparam logic [REG_AW-1:0] OFS_LCR  = 4'hC;

  // packed MSB first: dlab is bit 7, wlen is bits 1:0
  typedef struct packed {
    logic       dlab;
    logic       brk;
    logic       stick;
    logic       even;
    logic       par_en;
    logic       stop_sel;
    logic [1:0] wlen;
  } lcr_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } tx_state_e;
endpackage

// File: rtl/uart_lcr_regs.sv
module uart_lcr_regs
  import uart_tx_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [REG_AW-1:0]   addr_i,
  input  logic [REG_DW-1:0]   wdata_i,
  output logic [REG_DW-1:0]   rdata_o,
  output lcr_t                lcr_o,
  output logic                thr_we_o,
  output logic [7:0]          thr_data_o,
  output logic [15:0]         divisor_o
);
  lcr_t       lcr_q;
  logic [7:0] dll_q, dlh_q, ier_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcr_q <= '0;
      dll_q <= '0;
      dlh_q <= '0;
      ier_q <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        OFS_LCR:  lcr_q <= lcr_t'(wdata_i[7:0]);
        OFS_DATA: if (lcr_q.dlab) dll_q <= wdata_i[7:0];
        OFS_IER:  if (lcr_q.dlab) dlh_q <= wdata_i[7:0];
                  else            ier_q <= wdata_i[7:0];
        default: ;
      endcase
    end
  end

  assign thr_we_o   = we_i && (addr_i == OFS_DATA) && !lcr_q.dlab;
  assign thr_data_o = wdata_i[7:0];
  assign lcr_o      = lcr_q;
  assign divisor_o  = {dlh_q, dll_q};

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_LCR:  rdata_o[7:0] = lcr_q;
      OFS_DATA: rdata_o[7:0] = lcr_q.dlab ? dll_q : 8'h00;
      OFS_IER:  rdata_o[7:0] = lcr_q.dlab ? dlh_q : ier_q;
      default: ;
    endcase
  end

  AST_LCR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_LCR) |=> (lcr_q == $past(wdata_i[7:0]))); // R2
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       load_i,
  input  logic [7:0] load_data_i,
  input  logic [1:0] wlen_i,
  input  logic       stop_sel_i,
  input  logic       par_en_i,
  input  logic       even_i,
  input  logic       stick_i,
  output logic       line_o,
  output logic       busy_o,
  output logic       empty_o
);
  localparam int CNT_W = $clog2(2 * OVS);
  localparam logic [CNT_W-1:0] BIT_LAST    = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] STOP15_LAST = CNT_W'(OVS + OVS / 2 - 1);
  localparam logic [CNT_W-1:0] STOP2_LAST  = CNT_W'(2 * OVS - 1);

  tx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q, stop_last_q, cur_last;
  logic [2:0]       idx_q;
  logic [7:0]       shift_q, hold_q, mask;
  logic             hold_vld_q;
  logic [1:0]       wlen_q;
  logic             par_en_q, par_bit_q, par_calc, bit_done;

  // parity of the held byte, masked to the programmed length
  assign mask     = 8'hFF >> (2'd3 - wlen_i);
  assign par_calc = stick_i ? ~even_i
                  : (even_i ? ^(hold_q & mask) : ~^(hold_q & mask));
  assign cur_last = (state_q == ST_STOP) ? stop_last_q : BIT_LAST;
  assign bit_done = tick_i && (cnt_q == cur_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      idx_q       <= '0;
      shift_q     <= '0;
      hold_q      <= '0;
      hold_vld_q  <= 1'b0;
      wlen_q      <= '0;
      par_en_q    <= 1'b0;
      par_bit_q   <= 1'b0;
      stop_last_q <= BIT_LAST;
    end else begin
      if (load_i && !hold_vld_q) begin
        hold_q     <= load_data_i;
        hold_vld_q <= 1'b1;
      end
      if (state_q == ST_IDLE) begin
        if (hold_vld_q) begin
          state_q     <= ST_START;
          cnt_q       <= '0;
          shift_q     <= hold_q;
          hold_vld_q  <= 1'b0;
          wlen_q      <= wlen_i;
          par_en_q    <= par_en_i;
          par_bit_q   <= par_calc;
          stop_last_q <= !stop_sel_i ? BIT_LAST
                       : (wlen_i == 2'd0 ? STOP15_LAST : STOP2_LAST);
        end
      end else if (tick_i) begin
        cnt_q <= bit_done ? '0 : cnt_q + 1'b1;
        if (bit_done) begin
          unique case (state_q)
            ST_START: begin
              state_q <= ST_DATA;
              idx_q   <= '0;
            end
            ST_DATA: begin
              shift_q <= shift_q >> 1;
              if (idx_q == 3'd4 + {1'b0, wlen_q})
                state_q <= par_en_q ? ST_PAR : ST_STOP;
              else
                idx_q <= idx_q + 1'b1;
            end
            ST_PAR:  state_q <= ST_STOP;
            default: state_q <= ST_IDLE;
          endcase
        end
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: line_o = 1'b0;
      ST_DATA:  line_o = shift_q[0];
      ST_PAR:   line_o = par_bit_q;
      default:  line_o = 1'b1;
    endcase
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign empty_o = !hold_vld_q && (state_q == ST_IDLE);

  AST_EMPTY_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !busy_o); // R10
  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(wlen_q) && $stable(par_en_q)
      && $stable(par_bit_q) && $stable(stop_last_q))); // R11
  AST_NO_TICK_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i) |=> ($stable(state_q) && $stable(cnt_q))); // R12
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        baud_tick_i,
  input  logic        reg_we_i,
  input  logic [3:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic [15:0] divisor_o,
  output logic        txd_o,
  output logic        busy_o,
  output logic        temt_o
);
  lcr_t       lcr;
  logic       thr_we, line;
  logic [7:0] thr_data;

  uart_lcr_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .lcr_o      (lcr),
    .thr_we_o   (thr_we),
    .thr_data_o (thr_data),
    .divisor_o  (divisor_o)
  );

  uart_tx_core #(.OVS(OVS)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (baud_tick_i),
    .load_i      (thr_we),
    .load_data_i (thr_data),
    .wlen_i      (lcr.wlen),
    .stop_sel_i  (lcr.stop_sel),
    .par_en_i    (lcr.par_en),
    .even_i      (lcr.even),
    .stick_i     (lcr.stick),
    .line_o      (line),
    .busy_o      (busy_o),
    .empty_o     (temt_o)
  );

  // break acts on the pin only
  assign txd_o = lcr.brk ? 1'b0 : line;

  AST_BREAK_SPACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcr.brk |-> !txd_o); // R8
  AST_IDLE_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !lcr.brk) |-> txd_o); // R3
endmodule

// File: tb/uart_frame_tx_test.sv
`timescale 1ns/1ps
module uart_frame_tx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] divisor;
  logic        txd, busy, temt;
  int checks = 0, errors = 0;
  logic [255:0] tr;
  int n;

  always #2.5 clk = ~clk;

  uart_frame_tx uut (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(tick),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .divisor_o(divisor),
    .txd_o(txd), .busy_o(busy), .temt_o(temt)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  // record txd for every cycle busy is high
  task automatic capture(output logic [255:0] t, output int len);
    t = '1; len = 0;
    while (!busy) @(negedge clk);
    while (busy && len < 256) begin
      t[len] = txd;
      len++;
      @(negedge clk);
    end
  endtask

  task automatic verify(string tag, logic [7:0] lcr, logic [7:0] d,
                        logic [255:0] t, int len);
    int nb, stop_len, bits;
    logic [11:0] e;
    logic [7:0] m;
    logic p;
    int bad;
    nb = 5 + int'(lcr[1:0]);
    m = 8'hFF >> (3 - lcr[1:0]);
    p = lcr[5] ? ~lcr[4] : (lcr[4] ? ^(d & m) : ~^(d & m));
    stop_len = !lcr[2] ? 16 : (lcr[1:0] == 2'd0 ? 24 : 32);
    e = '1;
    e[0] = 1'b0;
    for (int i = 0; i < nb; i++) e[1+i] = d[i];
    bits = 1 + nb;
    if (lcr[3]) begin e[bits] = p; bits++; end
    bad = 0;
    for (int i = 0; i <= bits; i++)
      if (t[16*i+8] !== e[i]) bad++;
    chk({tag, " bits"}, bad, 0);
    chk({tag, " length"}, len, 16 * bits + stop_len);
  endtask

  task automatic send(string tag, logic [7:0] lcr, logic [7:0] d);
    wr(4'hC, {24'h0, lcr});
    wr(4'h0, {24'h0, d});
    capture(tr, n);
    verify(tag, lcr, d, tr, n);
  endtask

  task automatic t_reset;
    logic [31:0] r;
    rd(4'hC, r);
    chk("R1 lcr", int'(r), 0);
    chk("R1 txd", int'(txd), 1);
    chk("R1 busy", int'(busy), 0);
    chk("R1 temt", int'(temt), 1);
  endtask

  task automatic t_lcr_reg;
    logic [31:0] r;
    wr(4'hC, 32'hFFFF_FF7F);
    rd(4'hC, r);
    chk("R2 reserved reads zero", int'(r), 32'h7F);
    wr(4'hC, 32'h0);
  endtask

  task automatic t_formats;
    send("R3 8N1", 8'h03, 8'hA5);
    send("R3 6N1", 8'h01, 8'h2D);
    send("R6 5N1 eps/sticky ignored", 8'h30, 8'h13);
    send("R4 7E1", 8'h1A, 8'h53);
    send("R4 7O1", 8'h0A, 8'h53);
    send("R4 8E1 zero", 8'h1B, 8'h00);
    send("R5 sticky eps0", 8'h2B, 8'h01);
    send("R5 sticky eps1", 8'h3B, 8'h01);
  endtask

  task automatic t_stops;
    send("R7 5 bit 1.5 stop", 8'h04, 8'h15);
    send("R7 6 bit 2 stop", 8'h05, 8'h2A);
    send("R7 8 bit parity 2 stop", 8'h1F, 8'hF0);
  endtask

  task automatic t_break;
    int low;
    wr(4'hC, 32'h03);
    wr(4'h0, 32'hFF);
    fork
      capture(tr, n);
      begin
        while (!busy) @(negedge clk);
        repeat (20) @(negedge clk);
        wr(4'hC, 32'h43);
        repeat (40) @(negedge clk);
        wr(4'hC, 32'h03);
      end
    join
    low = 0;
    for (int i = 24; i < 60; i++) if (tr[i] !== 1'b0) low++;
    chk("R8 txd low under break", low, 0);
    chk("R8 frame length kept", n, 160);
    chk("R8 data restored after release", int'(tr[16*6+8]), 1);
  endtask

  task automatic t_dlab;
    logic [31:0] r;
    wr(4'hC, 32'h80);
    wr(4'h0, 32'h34);
    wr(4'h4, 32'h12);
    chk("R9 divisor", int'(divisor), 16'h1234);
    repeat (4) @(negedge clk);
    chk("R9 no frame from latch write", int'(busy), 0);
    chk("R9 temt kept", int'(temt), 1);
    rd(4'h0, r);
    chk("R9 read low latch", int'(r), 32'h34);
    wr(4'hC, 32'h03);
    wr(4'h4, 32'h0F);
    rd(4'h4, r);
    chk("R9 ier readback", int'(r), 32'h0F);
    chk("R9 divisor unchanged", int'(divisor), 16'h1234);
  endtask

  task automatic t_holding;
    int stray;
    wr(4'hC, 32'h03);
    wr(4'h0, 32'h11);
    while (!busy) @(negedge clk);
    wr(4'h0, 32'h5A);
    chk("R10 temt low while held", int'(temt), 0);
    wr(4'h0, 32'hC3);
    capture(tr, n);
    capture(tr, n);
    verify("R10 second byte", 8'h03, 8'h5A, tr, n);
    stray = 0;
    repeat (40) begin
      @(negedge clk);
      if (busy) stray++;
    end
    chk("R10 full slot write dropped", stray, 0);
    chk("R10 temt after drain", int'(temt), 1);
  endtask

  task automatic t_midcfg;
    wr(4'hC, 32'h03);
    wr(4'h0, 32'hC3);
    fork
      capture(tr, n);
      begin
        while (!busy) @(negedge clk);
        repeat (30) @(negedge clk);
        wr(4'hC, 32'h0C);
      end
    join
    verify("R11 mid-frame write", 8'h03, 8'hC3, tr, n);
    send("R11 next frame uses new", 8'h0C, 8'h1D);
  endtask

  task automatic t_tick;
    int moved;
    wr(4'hC, 32'h03);
    wr(4'h0, 32'h00);
    while (!busy) @(negedge clk);
    tick = 1'b0;
    moved = 0;
    repeat (100) begin
      @(negedge clk);
      if (txd !== 1'b0 || busy !== 1'b1) moved++;
    end
    chk("R12 frozen without ticks", moved, 0);
    tick = 1'b1;
    n = 0;
    while (busy) begin @(negedge clk); n++; end
    chk("R12 resumes full frame", n, 160);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lcr_reg();
    t_formats();
    t_stops();
    t_break();
    t_dlab();
    t_holding();
    t_midcfg();
    t_tick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule